// File: doc/BRIEF.md
# GPIO Configuration Slice with Event-Clock Divider

This block holds the two configuration words of a general-purpose I/O module. These are a control word and a pin-direction word, both reached over a simple synchronous bus with an address, a write strobe, write data and registered read data. From the control word it derives two signals. The first is a module-off signal that stands for the gating of all internal clock paths. The second is a one-cycle enable strobe that paces the event-detection logic at the full interface rate, or at one half, one quarter or one eighth of it.

The direction word is one bit per pin and active low: a 1 keeps the pin an input, and a 0 makes it an output. Its value goes straight to the pad-direction outputs and to nothing else. The module-off bit overrides the divider setting, but the bus keeps working while it is set, so software can always reconfigure or re-enable the module.

The strobe is paced by a free-running counter. Any write to the control word restarts the counter, so the first period after a change always has its full length.

Top module: `gpio_cfg_slice`

## Requirements
- R1: While reset is held and right after it, the control word reads 0x0000_0002, the direction word reads 0xFFFF_FFFF, `pad_dir_n` is all ones and `mod_off` is 0.
- R2: With the module on and divider code r in control bits 2:1, `evt_tick` is high in cycle k after the latest control write (or reset release, k = 0 being the first cycle) exactly when k mod 2^r = 2^r - 1. Code 0 gives a constant-high strobe.
- R3: When control bit 0 is 1, `mod_off` is high and `evt_tick` stays low for every divider code.
- R4: While the module is off, writes and reads of both words behave exactly as when it is on.
- R5: Control bits 31:3 always read as zero, and writing ones to them has no effect on the outputs.
- R6: The direction word at offset 0x4 is 32 bits wide and reads back as written. `pad_dir_n` equals it, with 1 meaning input and 0 meaning output, and it changes only on a write to 0x4.
- R7: Reads from any offset other than 0x0 and 0x4 return zero, and writes to such offsets change nothing.
- R8: `rd_data` is registered. It shows the word at the address presented before a clock edge, as it was before any write at that same edge.
- R9: A write to the control word restarts the strobe period from the next cycle, even when the divider code is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 4 | Byte offset of the word accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| evt_tick | output | 1 | Enable strobe for the event-detection logic |
| mod_off | output | 1 | Module-off indication; internal clock paths gated |
| pad_dir_n | output | 32 | Pad direction per pin, 1 = input |

## Verification
A corrupt divider counter shows on `evt_tick` within at most eight cycles, as a strobe in the wrong phase or with the wrong period. The bench therefore checks every cycle of a sixteen-cycle window after each control write, across all divider codes with the module both on and off. A wrong stored control or direction bit shows on `mod_off` or `pad_dir_n` in the cycle after the write, and on `rd_data` one cycle after the address is presented. Readbacks follow every write, including writes to unmapped offsets.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;
  localparam int RATIO_W = 2;
  localparam logic [3:0] CTRL_OFS = 4'h0;
  localparam logic [3:0] DIR_OFS  = 4'h4;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic               off;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{ratio: RATIO_W'(1), off: 1'b0};
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_cfg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PINS   = 32,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DW-1:0]     wdata,
  output ctrl_t             ctrl,
  output logic              ctrl_wr,
  output logic [PINS-1:0]   dir_n
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic sel_ctrl, sel_dir;

  assign sel_ctrl = (addr == ADDR_W'(CTRL_OFS));
  assign sel_dir  = (addr == ADDR_W'(DIR_OFS));
  assign ctrl_wr  = we && sel_ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= CTRL_RST;
    end else if (ctrl_wr) begin
      ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_n <= '1;
    end else if (we && sel_dir) begin
      dir_n <= wdata[PINS-1:0];
    end
  end

  p_dir_only_on_write_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(we && sel_dir) |-> $stable(dir_n));
endmodule

// File: rtl/gpio_evt_div.sv
module gpio_evt_div
  import gpio_cfg_pkg::*;
#(
  parameter int R_W = RATIO_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [R_W-1:0] ratio,
  input  logic           off,
  input  logic           restart,
  output logic           tick
);
  localparam int CNT_W = (1 << R_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst || off || restart) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  for (genvar i = 0; i < CNT_W; i++) begin : g_bit
    assign hit[i] = cnt[i] | (32'(i) >= 32'(ratio));
  end

  assign tick = !off && (&hit);

  p_held_while_off_r3: assert property (@(posedge clk) disable iff (rst)
    $past(off) |-> (cnt == '0));
endmodule

// File: rtl/gpio_cfg_rdmux.sv
module gpio_cfg_rdmux
  import gpio_cfg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PINS   = 32,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  ctrl_t             ctrl,
  input  logic [PINS-1:0]   dir_n,
  output logic [DW-1:0]     rd_data
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic [DW-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(CTRL_OFS)) begin
      rd_next[CTRL_W-1:0] = ctrl;
    end else if (addr == ADDR_W'(DIR_OFS)) begin
      rd_next[PINS-1:0] = dir_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/gpio_cfg_slice.sv
module gpio_cfg_slice
  import gpio_cfg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PINS   = 32,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     rd_data,
  output logic              evt_tick,
  output logic              mod_off,
  output logic [PINS-1:0]   pad_dir_n
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t ctrl;
  logic  ctrl_wr;

  gpio_cfg_regs #(.ADDR_W(ADDR_W), .PINS(PINS), .DW(DW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .we      (bus_we),
    .wdata   (bus_wdata),
    .ctrl    (ctrl),
    .ctrl_wr (ctrl_wr),
    .dir_n   (pad_dir_n)
  );

  gpio_evt_div #(.R_W(RATIO_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .ratio   (ctrl.ratio),
    .off     (ctrl.off),
    .restart (ctrl_wr),
    .tick    (evt_tick)
  );

  gpio_cfg_rdmux #(.ADDR_W(ADDR_W), .PINS(PINS), .DW(DW)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .addr    (bus_addr),
    .ctrl    (ctrl),
    .dir_n   (pad_dir_n),
    .rd_data (rd_data)
  );

  assign mod_off = ctrl.off;

  p_off_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
    mod_off |-> !evt_tick);

  p_full_rate_r2: assert property (@(posedge clk) disable iff (rst)
    (!mod_off && ctrl.ratio == '0) |-> evt_tick);

  p_no_tick_after_write_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_we && bus_addr == ADDR_W'(CTRL_OFS)) && !mod_off && ctrl.ratio != '0)
      |-> !evt_tick);

  p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr == ADDR_W'(CTRL_OFS)) |-> (rd_data[DW-1:CTRL_W] == '0));

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr != ADDR_W'(CTRL_OFS) && bus_addr != ADDR_W'(DIR_OFS))
      |-> (rd_data == '0));

  p_dir_readback_r6: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr == ADDR_W'(DIR_OFS)) |-> (rd_data[PINS-1:0] == $past(pad_dir_n)));
endmodule

// File: tb/gpio_cfg_slice_bench.sv
module gpio_cfg_slice_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = 4'h0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic        evt_tick, mod_off;
  logic [31:0] pad_dir_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_cfg_slice u_gpio_cfg_slice (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .evt_tick(evt_tick),
    .mod_off(mod_off), .pad_dir_n(pad_dir_n)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge of cycle 0 after the write
  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  // sample strobe for 16 cycles; k counts from the current negedge
  task automatic sweep(string req, int r, bit off);
    for (int k = 0; k < 16; k++) begin
      bit e;
      e = !off && ((k % (1 << r)) == ((1 << r) - 1));
      chk(req, {31'd0, evt_tick}, {31'd0, e});
      chk(req, {31'd0, mod_off}, {31'd0, off});
      @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk("R1", {31'd0, mod_off}, 32'd0);
    chk("R1", pad_dir_n, 32'hFFFF_FFFF);
    rst = 1'b0;
    sweep("R1 R2 reset divide-by-2", 1, 0);
    rd(4'h0, v); chk("R1", v, 32'h0000_0002);
    rd(4'h4, v); chk("R1", v, 32'hFFFF_FFFF);

    // exhaustive divider code x off sweep; reserved bits set on odd codes
    for (int r = 0; r < 4; r++) begin
      for (int d = 0; d < 2; d++) begin
        logic [31:0] w;
        w = {29'd0, r[1:0], d[0]};
        if (r % 2 == 1) w = w | 32'hFFFF_FFF8;
        wr(4'h0, w);
        sweep(d ? "R3" : "R2", r, d[0]);
        rd(4'h0, v); chk("R5 ctrl readback", v, {29'd0, r[1:0], d[0]});
      end
    end

    // R9: rewrite same code mid-period restarts phase
    wr(4'h0, 32'h0000_0006);
    repeat (5) @(negedge clk);
    wr(4'h0, 32'h0000_0006);
    sweep("R9", 3, 0);

    // R6 direction patterns
    for (int p = 0; p < 4; p++) begin
      logic [31:0] pat;
      pat = 32'hA5C3_0F96 ^ (32'h1111_1111 * p);
      wr(4'h4, pat);
      chk("R6 pad", pad_dir_n, pat);
      rd(4'h4, v); chk("R6 readback", v, pat);
    end

    // R7 unmapped offsets
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4) begin
        wr(a[3:0], 32'h0000_0000);
        rd(a[3:0], v); chk("R7 read", v, 32'd0);
      end
    end
    rd(4'h4, v); chk("R7 dir untouched", v, 32'hA5C3_0F96 ^ 32'h3333_3333);
    rd(4'h0, v); chk("R7 ctrl untouched", v, 32'h0000_0006);

    // R4 bus while off
    wr(4'h0, 32'h0000_0001);
    wr(4'h4, 32'h1234_5678);
    chk("R4 pad", pad_dir_n, 32'h1234_5678);
    rd(4'h4, v); chk("R4 readback", v, 32'h1234_5678);
    rd(4'h0, v); chk("R4 ctrl", v, 32'h0000_0001);
    wr(4'h0, 32'h0000_0000);
    chk("R4 re-enable", {31'd0, evt_tick}, 32'd1);

    // R8 read sees value before same-edge write
    bus_addr = 4'h4; bus_wdata = 32'hCAFE_0000; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    chk("R8 old value", rd_data, 32'h1234_5678);
    @(negedge clk);
    chk("R8 new value", rd_data, 32'hCAFE_0000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule